// File: doc/BRIEF.md
# Three-Stage Reconfigurable Nonlinear Pipeline

This block is a small pipeline of three processing stages whose order of use is not fixed. A multiplexer in front of each stage picks what that stage consumes next. The choices are the block's operand input or the latched output of any stage. One operand can therefore loop back and forth through the same hardware. The path it takes depends on the active function. Function A produces its result on result port A. Function B follows a different route and produces its result on result port B.

The pipeline is static: one function is configured at a time. A request to switch functions is recorded and holds the operand input closed. The new function takes effect only after every operand in flight has left the stages. Within one function, a new operand may start on any cycle in which its stage usage cannot collide with an operand already in flight. The block computes that condition from the function's route and lowers `in_ready` on the forbidden start spacings.

The stage operations are simple fixed-constant operations that stand in for real arithmetic:
- Stage 0 adds `K0`.
- Stage 1 rotates its value left by one bit and then adds `K1`.
- Stage 2 XORs its value with `K2`.

Because rotation is one of them, the order of visits changes the result.

Top module: `recfg_pipe3`

## Requirements
- R1: A synchronous active-high `rst` empties all three stages and selects function A (`active_func` = 0). In the first cycle after reset, `in_ready` is 1 and both result valids are 0.
- R2: With `active_func` = 0 (function A), the operand visits stage 0, 1, 2, 1, 2, 0 in that order, and the result appears on `res_a_data`.
- R3: With `active_func` = 1 (function B), the operand visits stage 0, 2, 1, 0, 1, 2 in that order, and the result appears on `res_b_data`.
- R4: An operand accepted in cycle c (`in_valid` and `in_ready` both high) has its result valid in cycle c+6, for exactly one cycle.
- R5: Under function A, `in_ready` is 0 in the cycles 2 and 5 after an accepted operand. Spacings of 1, 3 and 4 are allowed.
- R6: Under function B, `in_ready` is 0 in the cycles 2, 3 and 4 after an accepted operand. Spacings of 1 and 5 are allowed.
- R7: A `cfg_req` pulse carrying `cfg_func` (0 = A, 1 = B) drops `in_ready` from the next cycle. The new function becomes active in the cycle after the first cycle in which no operand is in flight. `in_ready` returns at that point.
- R8: At most one result valid is high in any cycle, and it is the one that belongs to `active_func`.
- R9: The stage operations are exact modulo 2^DW:
  - stage 0 computes x + K0;
  - stage 1 computes rotl(x,1) + K1, where rotl moves bit DW-1 into bit 0;
  - stage 2 computes x ^ K2.
- R10: An operand offered while `in_ready` is 0 is ignored and never produces a result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_req | input | 1 | Request to switch function (one-cycle pulse) |
| cfg_func | input | 1 | Requested function, 0 = A, 1 = B |
| in_valid | input | 1 | Operand offered |
| in_data | input | DW | Operand value |
| in_ready | output | 1 | Operand may start this cycle |
| res_a_valid | output | 1 | Function A result present |
| res_a_data | output | DW | Function A result |
| res_b_valid | output | 1 | Function B result present |
| res_b_data | output | DW | Function B result |
| active_func | output | 1 | Currently configured function, 0 = A, 1 = B |

## Verification
The assertions check the following on every cycle:
- the six-cycle latency from acceptance to result;
- the forbidden start spacings of each function;
- the drop of `in_ready` after a switch request;
- that the active function changes only on an empty pipeline;
- that only the port of the active function ever carries a result.

The result values themselves can only be shown by the bench's scenarios, against its behavioural model of the two routes. These values depend on the visit order through the rotating stage. The same is true of the following:
- edge operands that wrap the adder;
- operands stalled and then dropped while `in_ready` is low;
- the exact cycle at which a switch completes after a drain.

// File: rtl/nlp_pkg.sv
package nlp_pkg;
    localparam int NSTAGE = 3;
    localparam int NSTEP  = 6;
    localparam int SW     = $clog2(NSTAGE);
    localparam int PW     = $clog2(NSTEP);

    typedef enum logic {FN_A = 1'b0, FN_B = 1'b1} fn_e;
    typedef logic [SW-1:0] stage_id_t;
    typedef logic [PW-1:0] step_t;

    // Stage visited at a given step of each function's route.
    function automatic stage_id_t route(fn_e f, step_t s);
        stage_id_t r;
        r = '0;
        if (f == FN_A) begin
            case (s)
                3'd0: r = 2'd0;
                3'd1: r = 2'd1;
                3'd2: r = 2'd2;
                3'd3: r = 2'd1;
                3'd4: r = 2'd2;
                3'd5: r = 2'd0;
                default: r = 2'd0;
            endcase
        end else begin
            case (s)
                3'd0: r = 2'd0;
                3'd1: r = 2'd2;
                3'd2: r = 2'd1;
                3'd3: r = 2'd0;
                3'd4: r = 2'd1;
                3'd5: r = 2'd2;
                default: r = 2'd0;
            endcase
        end
        return r;
    endfunction

    // Bit d set: starting two operands d cycles apart makes them need one stage in one cycle.
    function automatic logic [NSTEP-1:1] forbid_mask(fn_e f);
        logic [NSTEP-1:1] m;
        m = '0;
        for (int d = 1; d < NSTEP; d++) begin
            for (int i = 0; i + d < NSTEP; i++) begin
                if (route(f, step_t'(i)) == route(f, step_t'(i + d))) begin
                    m[d] = 1'b1;
                end
            end
        end
        return m;
    endfunction
endpackage

// File: rtl/nlp_stage.sv
module nlp_stage
    import nlp_pkg::*;
#(
    parameter int            DW       = 16,
    parameter int            STAGE_ID = 0,
    parameter logic [DW-1:0] K        = '0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  fn_e                          func,
    input  logic                         start,
    input  logic [DW-1:0]                start_data,
    input  logic [NSTAGE-1:0]            tok_vld,
    input  step_t [NSTAGE-1:0]           tok_step,
    input  logic [NSTAGE-1:0][DW-1:0]    tok_data,
    output logic                         vld_q,
    output step_t                        step_q,
    output logic [DW-1:0]                data_q
);
    typedef struct packed {
        logic          vld;
        step_t         step;
        logic [DW-1:0] data;
    } lat_t;

    lat_t          r_d, r_q;
    logic          mux_hit;
    step_t         mux_step;
    logic [DW-1:0] mux_data;
    logic [DW-1:0] op_out;

    // Input multiplexer: pipeline input or any stage whose next route step lands here.
    always_comb begin
        step_t nxt;
        mux_hit  = 1'b0;
        mux_step = '0;
        mux_data = '0;
        nxt      = '0;
        if (start && route(func, '0) == stage_id_t'(STAGE_ID)) begin
            mux_hit  = 1'b1;
            mux_data = start_data;
        end
        for (int j = 0; j < NSTAGE; j++) begin
            nxt = tok_step[j] + step_t'(1);
            if (tok_vld[j] && tok_step[j] != step_t'(NSTEP - 1) &&
                route(func, nxt) == stage_id_t'(STAGE_ID)) begin
                mux_hit  = 1'b1;
                mux_step = nxt;
                mux_data = tok_data[j];
            end
        end
    end

    if (STAGE_ID == 0) begin : g_add
        assign op_out = mux_data + K;
    end else if (STAGE_ID == 1) begin : g_rot
        assign op_out = {mux_data[DW-2:0], mux_data[DW-1]} + K;
    end else begin : g_xor
        assign op_out = mux_data ^ K;
    end

    always_comb begin
        r_d.vld  = mux_hit;
        r_d.step = mux_step;
        r_d.data = op_out;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign vld_q  = r_q.vld;
    assign step_q = r_q.step;
    assign data_q = r_q.data;
endmodule

// File: rtl/nlp_admit.sv
module nlp_admit
    import nlp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  fn_e  func,
    input  logic start,
    output logic blocked
);
    localparam int HW = NSTEP - 1;

    typedef struct packed {
        logic [HW-1:0] hist;
    } adm_t;

    adm_t             s_d, s_q;
    logic [NSTEP-1:1] mask;

    // hist bit k: an operand started k+1 cycles ago.
    always_comb begin
        mask       = forbid_mask(func);
        blocked    = |(s_q.hist & mask);
        s_d.hist   = {s_q.hist[HW-2:0], start};
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/nlp_cfg.sv
module nlp_cfg
    import nlp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_req,
    input  fn_e  cfg_func,
    input  logic busy,
    output fn_e  func,
    output logic pend
);
    typedef struct packed {
        fn_e  func;
        logic pend;
        fn_e  pfunc;
    } cfg_t;

    cfg_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (c_q.pend) begin
            if (!busy) begin
                c_d.func = c_q.pfunc;
                c_d.pend = 1'b0;
            end
        end else if (cfg_req) begin
            c_d.pend  = 1'b1;
            c_d.pfunc = cfg_func;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '{func: FN_A, pend: 1'b0, pfunc: FN_A};
        else     c_q <= c_d;
    end

    assign func = c_q.func;
    assign pend = c_q.pend;
endmodule

// File: rtl/recfg_pipe3.sv
module recfg_pipe3
    import nlp_pkg::*;
#(
    parameter int            DW = 16,
    parameter logic [DW-1:0] K0 = 16'h1d3b,
    parameter logic [DW-1:0] K1 = 16'h00f1,
    parameter logic [DW-1:0] K2 = 16'ha5c3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_req,
    input  logic          cfg_func,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          res_a_valid,
    output logic [DW-1:0] res_a_data,
    output logic          res_b_valid,
    output logic [DW-1:0] res_b_data,
    output logic          active_func
);
    logic [NSTAGE-1:0]         stage_vld;
    step_t [NSTAGE-1:0]        stage_step;
    logic [NSTAGE-1:0][DW-1:0] stage_data;

    fn_e           func;
    logic          pend;
    logic          blocked;
    logic          start;
    logic          busy;
    logic          done;
    logic [DW-1:0] done_data;

    assign in_ready = !pend && !blocked;
    assign start    = in_valid && in_ready;
    assign busy     = |stage_vld;

    nlp_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_req  (cfg_req),
        .cfg_func (fn_e'(cfg_func)),
        .busy     (busy),
        .func     (func),
        .pend     (pend)
    );

    nlp_admit u_admit (
        .clk     (clk),
        .rst     (rst),
        .func    (func),
        .start   (start),
        .blocked (blocked)
    );

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        localparam logic [DW-1:0] KSEL = (g == 0) ? K0 : (g == 1) ? K1 : K2;
        nlp_stage #(
            .DW       (DW),
            .STAGE_ID (g),
            .K        (KSEL)
        ) u_stage (
            .clk        (clk),
            .rst        (rst),
            .func       (func),
            .start      (start),
            .start_data (in_data),
            .tok_vld    (stage_vld),
            .tok_step   (stage_step),
            .tok_data   (stage_data),
            .vld_q      (stage_vld[g]),
            .step_q     (stage_step[g]),
            .data_q     (stage_data[g])
        );
    end

    // Result tap: the stage holding an operand that has finished its last step.
    always_comb begin
        done      = 1'b0;
        done_data = '0;
        for (int j = 0; j < NSTAGE; j++) begin
            if (stage_vld[j] && stage_step[j] == step_t'(NSTEP - 1)) begin
                done      = 1'b1;
                done_data = stage_data[j];
            end
        end
    end

    assign res_a_valid = done && func == FN_A;
    assign res_b_valid = done && func == FN_B;
    assign res_a_data  = res_a_valid ? done_data : '0;
    assign res_b_data  = res_b_valid ? done_data : '0;
    assign active_func = func;
endmodule

// File: rtl/recfg_pipe3_chk.sv
module recfg_pipe3_chk (
    input logic clk,
    input logic rst,
    input logic cfg_req,
    input logic in_valid,
    input logic in_ready,
    input logic res_a_valid,
    input logic res_b_valid,
    input logic active_func,
    input logic busy
);
    // R8
    one_result_chk: assert property (@(posedge clk) disable iff (rst)
        !(res_a_valid && res_b_valid));
    // R8
    res_a_port_chk: assert property (@(posedge clk) disable iff (rst)
        res_a_valid |-> active_func == 1'b0);
    // R8
    res_b_port_chk: assert property (@(posedge clk) disable iff (rst)
        res_b_valid |-> active_func == 1'b1);
    // R4
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |-> ##6 (res_a_valid || res_b_valid));
    // R5
    a_gap2_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !active_func) |-> ##2 !in_ready);
    // R5
    a_gap5_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !active_func) |-> ##5 !in_ready);
    // R6
    b_gap2_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && active_func) |-> ##2 !in_ready);
    // R6
    b_gap3_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && active_func) |-> ##3 !in_ready);
    // R6
    b_gap4_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && active_func) |-> ##4 !in_ready);
    // R7
    req_closes_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_req |=> !in_ready);
    // R7
    switch_empty_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_func) |-> !$past(busy));
endmodule

bind recfg_pipe3 recfg_pipe3_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_req     (cfg_req),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .res_a_valid (res_a_valid),
    .res_b_valid (res_b_valid),
    .active_func (active_func),
    .busy        (busy)
);

// File: tb/recfg_pipe3_tb.sv
`timescale 1ns/1ps
module recfg_pipe3_tb;
    localparam logic [15:0] K0 = 16'h1d3b;
    localparam logic [15:0] K1 = 16'h00f1;
    localparam logic [15:0] K2 = 16'ha5c3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_req = 1'b0;
    logic        cfg_func = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_ready;
    logic        res_a_valid, res_b_valid;
    logic [15:0] res_a_data, res_b_data;
    logic        active_func;

    int    compared = 0;
    int    mismatched = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // behavioural model state
    int          m_cyc = 0;
    bit          m_func = 0, m_pend = 0, m_pfunc = 0;
    int          q_cyc[$];
    bit          q_f[$];
    logic [15:0] q_x[$];
    logic [15:0] stim = 16'h4c1f;

    always #5 clk = ~clk;

    recfg_pipe3 #(.DW(16), .K0(K0), .K1(K1), .K2(K2)) u_dut (
        .clk(clk), .rst(rst), .cfg_req(cfg_req), .cfg_func(cfg_func),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .res_a_valid(res_a_valid), .res_a_data(res_a_data),
        .res_b_valid(res_b_valid), .res_b_data(res_b_data),
        .active_func(active_func)
    );

    function automatic logic [15:0] stage_op(int s, logic [15:0] x);
        if (s == 0) return x + K0;
        if (s == 1) return {x[14:0], x[15]} + K1;
        return x ^ K2;
    endfunction

    // R2 / R3 routes
    function automatic logic [15:0] ref_eval(bit f, logic [15:0] x);
        int ra[6] = '{0, 1, 2, 1, 2, 0};
        int rb[6] = '{0, 2, 1, 0, 1, 2};
        logic [15:0] v = x;
        for (int k = 0; k < 6; k++) v = stage_op(f ? rb[k] : ra[k], v);
        return v;
    endfunction

    function automatic bit gap_forbidden(bit f, int d);
        if (!f) return (d == 2 || d == 5);
        return (d >= 2 && d <= 4);
    endfunction

    task automatic check1(string what, logic [15:0] got, logic [15:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s %s cycle %0d got %h expected %h", cur_req, what, m_cyc, got, exp);
        end
    endtask

    task automatic compare_and_advance();
        bit e_ready, e_busy, e_av, e_bv;
        logic [15:0] e_ad, e_bd;
        e_ready = !m_pend; e_busy = 0; e_av = 0; e_bv = 0; e_ad = '0; e_bd = '0;
        foreach (q_cyc[i]) begin
            int d = m_cyc - q_cyc[i];
            if (gap_forbidden(m_func, d)) e_ready = 0;
            if (d >= 1 && d <= 6) e_busy = 1;
            if (d == 6) begin
                if (q_f[i]) begin e_bv = 1; e_bd = ref_eval(1, q_x[i]); end
                else        begin e_av = 1; e_ad = ref_eval(0, q_x[i]); end
            end
        end
        check1("in_ready", {15'd0, in_ready}, {15'd0, e_ready});
        check1("active_func", {15'd0, active_func}, {15'd0, m_func});
        check1("res_a_valid", {15'd0, res_a_valid}, {15'd0, e_av});
        check1("res_b_valid", {15'd0, res_b_valid}, {15'd0, e_bv});
        if (e_av) check1("res_a_data", res_a_data, e_ad);
        if (e_bv) check1("res_b_data", res_b_data, e_bd);
        // advance: R10 only accepted operands enter
        if (in_valid && e_ready) begin
            q_cyc.push_back(m_cyc); q_f.push_back(m_func); q_x.push_back(in_data);
        end
        if (m_pend) begin
            if (!e_busy) begin m_func = m_pfunc; m_pend = 0; end
        end else if (cfg_req) begin
            m_pend = 1; m_pfunc = cfg_func;
        end
        while (q_cyc.size() > 0 && m_cyc - q_cyc[0] >= 6) begin
            void'(q_cyc.pop_front()); void'(q_f.pop_front()); void'(q_x.pop_front());
        end
        m_cyc++;
    endtask

    task automatic tick();
        @(negedge clk);
        compare_and_advance();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(bit v, logic [15:0] d, bit cr, bit cf);
        in_valid = v; in_data = d; cfg_req = cr; cfg_func = cf;
        tick();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 16'h0, 0, 0);
    endtask

    task automatic stream(int n);
        for (int i = 0; i < n; i++) begin
            stim = stim * 16'd25173 + 16'd13849;
            drive(1, stim, 0, 0);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired at model cycle %0d", m_cyc);
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        cur_req = "R1"; idle(3);                      // reset state
        cur_req = "R2"; drive(1, 16'h1234, 0, 0); idle(8);
        cur_req = "R4"; drive(1, 16'h0f0f, 0, 0); idle(8);
        cur_req = "R9"; drive(1, 16'hffff, 0, 0); idle(7);
        drive(1, 16'h0000, 0, 0); idle(7);
        drive(1, 16'h8000, 0, 0); idle(7);
        cur_req = "R5"; stream(24); idle(8);           // A spacing, stalled offers
        cur_req = "R10";
        for (int i = 0; i < 12; i++) drive(i % 3 != 0, 16'h5a00 + 16'(i), 0, 0);
        idle(8);
        cur_req = "R7"; stream(3);                      // switch to B while busy
        stim = stim + 16'h0101; drive(1, stim, 1, 1);
        stream(10); idle(4);
        cur_req = "R6"; stream(24); idle(8);
        cur_req = "R3"; drive(1, 16'h7e81, 0, 0); idle(8);
        cur_req = "R8"; stream(4);                      // switch back to A
        drive(1, 16'h3c3c, 1, 0); stream(12); idle(8);
        cur_req = "R7"; drive(0, 16'h0, 1, 1); idle(3); // switch on empty pipe
        drive(0, 16'h0, 1, 0); idle(3);
        cur_req = "R2"; stream(6); idle(8);
        summary();
    end
endmodule